// File: doc/BRIEF.md
# Serial Control and Diagnostic Exchange Port

This block is the serial slave port of an eight-channel output controller. A host frames each transfer with an active-low select. Each frame exchanges one byte in each direction through a single 8-bit register. The outgoing byte is a snapshot of the eight per-channel diagnostic flags, taken when the select goes low. The incoming byte is the new on/off pattern for the channels. The received byte takes effect only when the select is released, and only when the frame had exactly eight clock periods.

The serial pins are sampled in the block's own system clock domain. Each pin passes through a two-stage synchronizer, and the edges of the serial clock and the select are found in that domain. The controller launches on the rising serial clock edge and captures on the falling one. The diagnostic flags and the control bits share one channel-to-bit layout, so the byte shifted out lines up with the byte shifted in:

- Odd channels 1, 3, 5 and 7 occupy bits 7 down to 4.
- Even channels 0, 2, 4 and 6 occupy bits 3 down to 0.

A host can write a pattern, wait for the outputs to settle, and then send the same pattern again. It then compares the echo bit by bit. The block also presents the committed byte as a per-channel enable vector.

Top module: `spi_diag_port`

## Requirements
- R1: While reset is high and in the first cycle after it, `ctrl_word` and `chan_on` are all zeros and `miso_out` is high impedance.
- R2: `miso_out` is high impedance whenever the synchronized select is high. It is driven from three system clocks after `cs_n_in` falls until three system clocks after `cs_n_in` rises.
- R3: On the select falling edge, the diagnostic vector is loaded with channel k placed in the following frame bit:
  - an odd k goes to bit 7-(k-1)/2;
  - an even k goes to bit 3-k/2.

  The frame is sent MSB first, so the serial order is Diag1, Diag3, Diag5, Diag7, Diag0, Diag2, Diag4, Diag6. Bit 7 appears when the select falls, and each later bit follows a rising `sck_in` edge.
- R4: Changes of `diag_in` after the select has fallen do not alter the byte shifted out in that frame.
- R5: `mosi_in` is sampled on each falling `sck_in` edge while the select is low, MSB first. When the select rises after exactly eight falling edges, the received byte is written to `ctrl_word`.
- R6: When the select rises after any other number of falling edges (0, 7 or 9, for example), `ctrl_word` keeps its previous value.
- R7: Serial clock and data activity while the select is high has no effect. `ctrl_word` changes only on the rising edge of the select.
- R8: `chan_on[k]` equals the `ctrl_word` bit at the frame position given for channel k in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Serial clock from host, asynchronous |
| cs_n_in | input | 1 | Active-low frame select from host, asynchronous |
| mosi_in | input | 1 | Serial data from host |
| miso_out | output | 1 | Serial data to host, high impedance outside a frame |
| diag_in | input | 8 | Per-channel diagnostic flags, bit k is channel k |
| ctrl_word | output | 8 | Committed control byte in frame bit order |
| chan_on | output | 8 | Per-channel enable decoded from the control byte |

## Verification
The hardest case to reach from the pins is a diagnostic change that lands inside an open frame after the snapshot has been taken. The bench flips every bit of `diag_in` a few clocks after lowering the select, while the serial clock is still idle. It then checks that the echoed byte still reflects the pre-flip pattern. Frames with an illegal length are also hard to reach. The bench forms them by cutting the bit loop short or running it past eight, and it also toggles the serial clock with the select high. After each of these cases it reads back `ctrl_word` and checks it against the previously committed byte.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;

    localparam int unsigned CH_N   = 8;
    localparam int unsigned HALF_N = CH_N / 2;

    typedef logic [CH_N-1:0] chan_vec_t;

    // Events derived from the synchronized pins, one cycle wide
    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_fall;
        logic cs_rise;
        logic cs_low;
        logic mosi;
    } pin_ev_t;

    // Frame bit that carries channel ch: odd channels fill the upper half
    function automatic int unsigned frame_pos(input int unsigned ch);
        if ((ch % 2) == 1)
            return CH_N - 1 - (ch / 2);
        else
            return HALF_N - 1 - (ch / 2);
    endfunction

    // Reorder a per-channel vector into frame bit order
    function automatic chan_vec_t pack_chan(input chan_vec_t d);
        chan_vec_t w;
        w = '0;
        for (int k = 0; k < CH_N; k++) begin
            w[frame_pos(k)] = d[k];
        end
        return w;
    endfunction

endpackage

// File: rtl/spi_diag_sync.sv
module spi_diag_sync #(
    parameter int unsigned   W       = 3,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= RST_VAL;
            end
            prev <= RST_VAL;
        end else begin
            stg[0] <= d_in;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
            prev <= stg[STAGES-1];
        end
    end

    assign lvl  = stg[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

endmodule

// File: rtl/spi_diag_shifter.sv
module spi_diag_shifter
    import spi_diag_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  pin_ev_t          ev,
    input  chan_vec_t        diag_word,
    output chan_vec_t        shreg,
    output logic             miso_d,
    output logic             miso_en,
    output logic [CNT_W-1:0] fall_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    chan_vec_t        sr_q;
    logic             miso_q;
    logic             en_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            miso_q <= 1'b0;
            en_q   <= 1'b0;
            cnt_q  <= '0;
        end else if (ev.cs_fall) begin
            sr_q   <= diag_word;
            miso_q <= diag_word[CH_N-1];
            en_q   <= 1'b1;
            cnt_q  <= '0;
        end else if (ev.cs_rise) begin
            en_q   <= 1'b0;
        end else if (ev.cs_low) begin
            if (ev.sck_rise) begin
                miso_q <= sr_q[CH_N-1];
            end
            if (ev.sck_fall) begin
                sr_q <= {sr_q[CH_N-2:0], ev.mosi};
                if (cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign shreg    = sr_q;
    assign miso_d   = miso_q;
    assign miso_en  = en_q;
    assign fall_cnt = cnt_q;

endmodule

// File: rtl/spi_diag_ctrlreg.sv
module spi_diag_ctrlreg
    import spi_diag_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_rise,
    input  logic [CNT_W-1:0] fall_cnt,
    input  chan_vec_t        shreg,
    output chan_vec_t        ctrl_word,
    output chan_vec_t        chan_on
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(CH_N);

    chan_vec_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (cs_rise && (fall_cnt == FULL_CNT)) begin
            ctrl_q <= shreg;
        end
    end

    assign ctrl_word = ctrl_q;

    for (genvar k = 0; k < CH_N; k++) begin : g_chan
        assign chan_on[k] = ctrl_q[frame_pos(k)];
    end

endmodule

// File: rtl/spi_diag_port.sv
module spi_diag_port
    import spi_diag_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sck_in,
    input  logic            cs_n_in,
    input  logic            mosi_in,
    output logic            miso_out,
    input  logic [CH_N-1:0] diag_in,
    output logic [CH_N-1:0] ctrl_word,
    output logic [CH_N-1:0] chan_on
);

    localparam int unsigned PIN_W   = 3;
    localparam int unsigned IX_SCK  = 2;
    localparam int unsigned IX_CS   = 1;
    localparam int unsigned IX_MOSI = 0;
    localparam logic [PIN_W-1:0] PIN_IDLE = 3'b010;

    logic [PIN_W-1:0] pin_lvl, pin_rise, pin_fall;
    pin_ev_t          ev;
    chan_vec_t        diag_word;
    chan_vec_t        shreg;
    logic             miso_d, miso_en;
    logic [CNT_W-1:0] fall_cnt;
    logic             cs_rise, cs_fall, cs_low;

    spi_diag_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) sync_i (
        .clk  (clk),
        .rst  (rst),
        .d_in ({sck_in, cs_n_in, mosi_in}),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign cs_low  = ~pin_lvl[IX_CS];
    assign cs_rise = pin_rise[IX_CS];
    assign cs_fall = pin_fall[IX_CS];

    always_comb begin
        ev          = '0;
        ev.sck_rise = pin_rise[IX_SCK] & cs_low;
        ev.sck_fall = pin_fall[IX_SCK] & cs_low;
        ev.cs_fall  = cs_fall;
        ev.cs_rise  = cs_rise;
        ev.cs_low   = cs_low;
        ev.mosi     = pin_lvl[IX_MOSI];
    end

    assign diag_word = pack_chan(diag_in);

    spi_diag_shifter #(
        .CNT_W (CNT_W)
    ) shift_i (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .diag_word (diag_word),
        .shreg     (shreg),
        .miso_d    (miso_d),
        .miso_en   (miso_en),
        .fall_cnt  (fall_cnt)
    );

    spi_diag_ctrlreg #(
        .CNT_W (CNT_W)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .cs_rise   (cs_rise),
        .fall_cnt  (fall_cnt),
        .shreg     (shreg),
        .ctrl_word (ctrl_word),
        .chan_on   (chan_on)
    );

    assign miso_out = miso_en ? miso_d : 1'bz;

endmodule

// File: rtl/spi_diag_port_chk.sv
module spi_diag_port_chk
    import spi_diag_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_rise,
    input logic             cs_fall,
    input logic             cs_low,
    input logic [CNT_W-1:0] fall_cnt,
    input chan_vec_t        shreg,
    input chan_vec_t        ctrl_word,
    input logic             miso_en,
    input logic             miso_d,
    input chan_vec_t        diag_in
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(CH_N);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (ctrl_word == '0) && !miso_en);

    p_release_r2: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> miso_en);

    p_idle_hiz_r2: assert property (@(posedge clk) disable iff (rst)
        (!cs_low && !cs_fall) |=> !miso_en);

    p_first_bit_r3: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> (miso_d == $past(diag_in[1])));

    p_commit_r5: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && (fall_cnt == FULL_CNT)) |=> (ctrl_word == $past(shreg)));

    p_reject_r6: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && (fall_cnt != FULL_CNT)) |=> $stable(ctrl_word));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !cs_rise |=> $stable(ctrl_word));

endmodule

bind spi_diag_port spi_diag_port_chk #(
    .CNT_W (CNT_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cs_rise   (cs_rise),
    .cs_fall   (cs_fall),
    .cs_low    (cs_low),
    .fall_cnt  (fall_cnt),
    .shreg     (shreg),
    .ctrl_word (ctrl_word),
    .miso_en   (miso_en),
    .miso_d    (miso_d),
    .diag_in   (diag_in)
);

// File: tb/spi_diag_port_tb.sv
module spi_diag_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic [7:0] diag = 8'h00;
    wire        miso;
    logic [7:0] ctrl_word;
    logic [7:0] chan_on;

    int n_checks = 0;
    int n_errors = 0;
    bit driven_all;

    always #10 clk = ~clk;

    spi_diag_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .sck_in    (sck),
        .cs_n_in   (cs_n),
        .mosi_in   (mosi),
        .miso_out  (miso),
        .diag_in   (diag),
        .ctrl_word (ctrl_word),
        .chan_on   (chan_on)
    );

    function automatic logic [7:0] exp_frame(input logic [7:0] d);
        return {d[1], d[3], d[5], d[7], d[0], d[2], d[4], d[6]};
    endfunction

    function automatic logic [7:0] exp_chan(input logic [7:0] w);
        logic [7:0] c;
        c[1] = w[7]; c[3] = w[6]; c[5] = w[5]; c[7] = w[4];
        c[0] = w[3]; c[2] = w[2]; c[4] = w[1]; c[6] = w[0];
        return c;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One frame: nbits serial clock periods, optional diag flip after select falls
    task automatic run_frame(input logic [7:0] tx, input int nbits, input bit flip,
                             output logic [7:0] rx);
        rx = 8'h00;
        driven_all = 1'b1;
        cs_n = 1'b0;
        wait_clk(4);
        if (flip) diag = ~diag;
        wait_clk(2);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? tx[7-i] : 1'b0;
            sck = 1'b1;
            wait_clk(4);
            if (miso === 1'bz) driven_all = 1'b0;
            if (i < 8) rx[7-i] = miso;
            sck = 1'b0;
            wait_clk(4);
        end
        cs_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        wait_clk(5);
        check8("R1 ctrl_word in reset", ctrl_word, 8'h00);
        check8("R1 chan_on in reset", chan_on, 8'h00);
        check1("R1 miso hiz in reset", miso, 1'bz);
        rst = 1'b0;
        wait_clk(1);
        check8("R1 ctrl_word after reset", ctrl_word, 8'h00);
        check1("R2 miso hiz idle", miso, 1'bz);
    endtask

    task automatic t_basic;
        logic [7:0] rx;
        diag = 8'h3C;
        run_frame(8'hA5, 8, 1'b0, rx);
        check8("R3 echo of diag 3C", rx, exp_frame(8'h3C));
        check1("R2 miso driven in frame", driven_all, 1'b1);
        check1("R2 miso hiz after frame", miso, 1'bz);
        check8("R5 commit A5", ctrl_word, 8'hA5);
        check8("R8 chan_on for A5", chan_on, exp_chan(8'hA5));
    endtask

    task automatic t_walk;
        logic [7:0] rx;
        for (int k = 0; k < 8; k++) begin
            diag = 8'h01 << k;
            run_frame(8'h01 << k, 8, 1'b0, rx);
            check8("R3 single channel position", rx, exp_frame(8'h01 << k));
            check8("R5 walking commit", ctrl_word, 8'h01 << k);
            check8("R8 walking decode", chan_on, exp_chan(8'h01 << k));
        end
    endtask

    task automatic t_snapshot;
        logic [7:0] rx;
        diag = 8'h96;
        run_frame(8'hC3, 8, 1'b1, rx);
        check8("R4 snapshot unaffected by diag change", rx, exp_frame(8'h96));
        check8("R5 commit C3", ctrl_word, 8'hC3);
        diag = 8'h69;
        run_frame(8'hC3, 8, 1'b0, rx);
        check8("R4 new frame takes new snapshot", rx, exp_frame(8'h69));
    endtask

    task automatic t_bad_len;
        logic [7:0] rx;
        run_frame(8'h5A, 7, 1'b0, rx);
        check8("R6 seven-bit frame rejected", ctrl_word, 8'hC3);
        run_frame(8'h5A, 9, 1'b0, rx);
        check8("R6 nine-bit frame rejected", ctrl_word, 8'hC3);
        run_frame(8'h5A, 0, 1'b0, rx);
        check8("R6 empty frame rejected", ctrl_word, 8'hC3);
        check8("R8 decode kept after reject", chan_on, exp_chan(8'hC3));
    endtask

    task automatic t_idle_sck;
        logic [7:0] rx;
        mosi = 1'b1;
        for (int i = 0; i < 10; i++) begin
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
            wait_clk(4);
        end
        wait_clk(4);
        check8("R7 idle clocks leave ctrl_word", ctrl_word, 8'hC3);
        check1("R7 idle clocks keep miso hiz", miso, 1'bz);
        diag = 8'hF0;
        run_frame(8'h3E, 8, 1'b0, rx);
        check8("R7 next frame commits normally", ctrl_word, 8'h3E);
        check8("R3 echo of diag F0", rx, exp_frame(8'hF0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_walk();
        t_snapshot();
        t_bad_len();
        t_idle_sck();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule